// File: doc/BRIEF.md
# Timer with Shared Prescaler and Watchdog

This block holds an 8-bit event counter and an 8-bit watchdog timer. The two share a single 8-bit prescaler, which is given to one of them at a time. The counter advances on one of two sources:
- the instruction-cycle clock enable, or
- a selected edge of an already synchronised input pin.

The watchdog advances on a free-running tick. It emits a one-cycle time-out pulse when its count rolls over. Software clears the watchdog with a clear strobe or a sleep strobe. It can read and load the counter through a data port.

A 6-bit mode register sets the behaviour. Bits 2..0 hold the ratio code. Bit 3 assigns the prescaler: 0 gives it to the counter, 1 to the watchdog. Bit 4 picks the pin edge: 0 is rising, 1 is falling. Bit 5 picks the counter source: 0 is the cycle clock, 1 is the pin. The same ratio code divides by 2^(code+1) for the counter and by 2^code for the watchdog. The side that does not hold the prescaler sees every one of its own events.

Top module: `tmr_wdt_core`

## Requirements
- R1: While rst_ni is low and after it rises, mode_o reads 6'h3F. The watchdog count is zero, so with the prescaler later given to the counter the first time-out comes on the 256th tick. cnt_ovf_o and wdt_to_o are low.
- R2: With mode bit 5 = 0 and bit 3 = 0, the counter advances once per 2^(code+1) cycles in which cyc_en_i is high. The code is mode bits 2..0, counted from a cleared prescaler.
- R3: With mode bit 3 = 1, the counter advances on every selected event, whatever the ratio code.
- R4: With mode bit 5 = 1, the counter events are pin_i transitions, with cyc_en_i ignored. Bit 4 = 0 counts 0-to-1 transitions and bit 4 = 1 counts 1-to-0 transitions. The count is visible on cnt_o one cycle after the pin changes.
- R5: cnt_we_i loads cnt_wdata_i into the counter, overriding an increment in that cycle. When mode bit 3 = 0, it also clears the prescaler.
- R6: The counter wraps from 8'hFF to 8'h00. cnt_ovf_o is high for exactly the one cycle after the wrap.
- R7: With mode bit 3 = 0, the watchdog advances on every wdt_tick_i. wdt_to_o pulses for one cycle after the 256th tick counted from a clear.
- R8: With mode bit 3 = 1, the watchdog advances once per 2^code ticks. The time-out comes after 256*2^code ticks counted from a clear.
- R9: wdt_clr_i or sleep_i zeroes the watchdog count. When mode bit 3 = 1, it also clears the prescaler.
- R10: The counter value is held unchanged through an assertion of rst_ni.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cyc_en_i | input | 1 | Instruction-cycle clock enable |
| pin_i | input | 1 | Synchronised external count pin |
| wdt_tick_i | input | 1 | Free-running watchdog tick |
| wdt_clr_i | input | 1 | Clear-watchdog strobe |
| sleep_i | input | 1 | Sleep strobe, also clears the watchdog |
| cnt_we_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | 8 | Counter write data |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 6 | Mode register write data |
| mode_o | output | 6 | Mode register read value |
| cnt_o | output | 8 | Counter value |
| cnt_ovf_o | output | 1 | One-cycle counter wrap pulse |
| wdt_to_o | output | 1 | One-cycle watchdog time-out pulse |

## Verification
A stale or misrouted prescaler count shows up as a counter value one step early or late after a known number of events. On the watchdog side it moves the time-out by at least one tick, so the bench records the exact tick index at which wdt_to_o first rises. A watchdog count that the clear or sleep strobes fail to zero makes the time-out arrive before 256 ticks have passed since the strobe. A wrong edge or source choice changes cnt_o in the very cycle after the pin moves.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CNT_W   = 8;
  localparam int unsigned RATIO_W = 3;
  localparam int unsigned MODE_W  = RATIO_W + 3;

  typedef struct packed {
    logic               src_pin;  // 1: pin edges, 0: cycle clock
    logic               fall;     // 1: falling edge
    logic               to_wdt;   // prescaler owner
    logic [RATIO_W-1:0] ratio;
  } tmr_mode_t;

  localparam logic [MODE_W-1:0] MODE_RST = '1;
endpackage

// File: rtl/tmr_edge_sel.sv
module tmr_edge_sel (
  input  logic clk_i,
  input  logic pin_i,
  input  logic cyc_en_i,
  input  logic src_pin_i,
  input  logic fall_i,
  output logic evt_o
);
  logic pin_q;

  // no reset: previous pin level is always valid, no false edge at release
  always_ff @(posedge clk_i) pin_q <= pin_i;

  logic pin_edge;
  assign pin_edge = fall_i ? (pin_q & ~pin_i) : (~pin_q & pin_i);
  assign evt_o    = src_pin_i ? pin_edge : cyc_en_i;
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned W = 8,
  localparam int unsigned KW = $clog2(W + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          evt_i,
  input  logic          clr_i,
  input  logic [KW-1:0] shift_i,   // divide by 2**shift_i
  output logic          pass_o
);
  logic [W-1:0] pre_q;
  logic [W:0]   mask_w;
  logic [W-1:0] mask;

  assign mask_w = ({{W{1'b0}}, 1'b1} << shift_i) - 1'b1;
  assign mask   = mask_w[W-1:0];
  assign pass_o = evt_i & ((pre_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pre_q <= '0;
    else if (clr_i) pre_q <= '0;
    else if (evt_i) pre_q <= pre_q + 1'b1;
  end

  a_r9_pre_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> pre_q == '0);
  a_r2_pass_needs_evt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_i |-> !pass_o);
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned W       = 8,
  parameter bit          HAS_RST = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o,
  output logic         ovf_o
);
  logic [W-1:0] q_q;
  logic         ovf_q;

  generate
    if (HAS_RST) begin : g_rst
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     q_q <= '0;
        else if (load_i) q_q <= load_val_i;
        else if (inc_i)  q_q <= q_q + 1'b1;
      end
    end else begin : g_keep
      always_ff @(posedge clk_i) begin
        if (load_i)     q_q <= load_val_i;
        else if (inc_i) q_q <= q_q + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else         ovf_q <= inc_i & ~load_i & (&q_q);
  end

  assign q_o   = q_q;
  assign ovf_o = ovf_q;

  a_r5_r9_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> q_o == $past(load_val_i));
  a_r6_ovf_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> q_o == '0);
  a_r6_ovf_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> !ovf_o);
endmodule

// File: rtl/tmr_wdt_core.sv
module tmr_wdt_core
  import tmr_pkg::*;
#(
  parameter int unsigned PRE_W = 8,
  parameter int unsigned WDT_W = 8,
  localparam int unsigned KW = $clog2(PRE_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_en_i,
  input  logic              pin_i,
  input  logic              wdt_tick_i,
  input  logic              wdt_clr_i,
  input  logic              sleep_i,
  input  logic              cnt_we_i,
  input  logic [CNT_W-1:0]  cnt_wdata_i,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              cnt_ovf_o,
  output logic              wdt_to_o
);
  tmr_mode_t mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= tmr_mode_t'(MODE_RST);
    else if (mode_we_i) mode_q <= tmr_mode_t'(mode_wdata_i);
  end
  assign mode_o = mode_q;

  logic cnt_evt;
  tmr_edge_sel u_edge (
    .clk_i     (clk_i),
    .pin_i     (pin_i),
    .cyc_en_i  (cyc_en_i),
    .src_pin_i (mode_q.src_pin),
    .fall_i    (mode_q.fall),
    .evt_o     (cnt_evt)
  );

  logic          wdt_clr;
  logic          pre_evt, pre_clr, pre_pass;
  logic [KW-1:0] pre_shift;

  assign wdt_clr   = wdt_clr_i | sleep_i;
  assign pre_evt   = mode_q.to_wdt ? wdt_tick_i : cnt_evt;
  assign pre_clr   = mode_q.to_wdt ? wdt_clr : cnt_we_i;
  // counter side divides one step further than the watchdog side
  assign pre_shift = mode_q.to_wdt ? KW'(mode_q.ratio) : KW'(mode_q.ratio) + 1'b1;

  tmr_prescaler #(.W(PRE_W)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (pre_evt),
    .clr_i   (pre_clr),
    .shift_i (pre_shift),
    .pass_o  (pre_pass)
  );

  logic cnt_inc, wdt_inc;
  assign cnt_inc = mode_q.to_wdt ? cnt_evt : pre_pass;
  assign wdt_inc = mode_q.to_wdt ? pre_pass : wdt_tick_i;

  tmr_count #(.W(CNT_W), .HAS_RST(1'b0)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_we_i),
    .load_val_i (cnt_wdata_i),
    .inc_i      (cnt_inc),
    .q_o        (cnt_o),
    .ovf_o      (cnt_ovf_o)
  );

  logic [WDT_W-1:0] wdt_q;
  tmr_count #(.W(WDT_W), .HAS_RST(1'b1)) u_wdt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wdt_clr),
    .load_val_i ('0),
    .inc_i      (wdt_inc),
    .q_o        (wdt_q),
    .ovf_o      (wdt_to_o)
  );

  a_r4_pin_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.src_pin && !cnt_we_i && $stable(pin_i)) |=> $stable(cnt_o));
  a_r9_no_to_after_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_clr |=> !wdt_to_o);
  a_r7_to_wdt_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_to_o |-> wdt_q == '0);
endmodule

// File: tb/sim_tmr_wdt_core.sv
module sim_tmr_wdt_core;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_ni = 1'b0;
  logic cyc_en = 0, pin = 0, tick = 0, wclr = 0, slp = 0, cwe = 0, mwe = 0;
  logic [7:0] cwd = 0;
  logic [5:0] mwd = 0;
  logic [5:0] mode_o;
  logic [7:0] cnt_o;
  logic ovf_o, to_o;

  tmr_wdt_core u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cyc_en_i(cyc_en), .pin_i(pin),
    .wdt_tick_i(tick), .wdt_clr_i(wclr), .sleep_i(slp),
    .cnt_we_i(cwe), .cnt_wdata_i(cwd), .mode_we_i(mwe), .mode_wdata_i(mwd),
    .mode_o(mode_o), .cnt_o(cnt_o), .cnt_ovf_o(ovf_o), .wdt_to_o(to_o)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask
  task automatic wr_mode(logic [5:0] m); mwd = m; mwe = 1; cyc(); mwe = 0; endtask
  task automatic wr_cnt(logic [7:0] v); cwd = v; cwe = 1; cyc(); cwe = 0; endtask
  task automatic wclear(); wclr = 1; cyc(); wclr = 0; endtask

  // tick the watchdog until the first time-out, return its tick index
  task automatic ticks_to_timeout(int lim, output int idx);
    idx = 0;
    for (int i = 1; i <= lim; i++) begin
      tick = 1; cyc();
      if (to_o && idx == 0) idx = i;
    end
    tick = 0;
  endtask

  // {mode[7:0], events[15:0], expected count[7:0]}
  localparam int NV = 7;
  localparam logic [31:0] VEC [NV] = '{
    {8'h00, 16'd10,  8'd5},   // R2 1:2
    {8'h01, 16'd20,  8'd5},   // R2 1:4
    {8'h02, 16'd17,  8'd2},   // R2 1:8
    {8'h03, 16'd33,  8'd2},   // R2 1:16
    {8'h07, 16'd300, 8'd1},   // R2 1:256
    {8'h08, 16'd7,   8'd7},   // R3 undivided
    {8'h0F, 16'd260, 8'd4}    // R3 undivided, wraps
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int idx;
    cyc(); cyc();
    chk("R1 mode in reset", mode_o, 6'h3F);
    chk("R1 to in reset", to_o, 0);
    rst_ni = 1; cyc();
    chk("R1 mode after reset", mode_o, 6'h3F);
    chk("R1 ovf after reset", ovf_o, 0);

    // R1/R7: watchdog starts at zero, undivided when prescaler on counter
    wr_mode(6'h00);
    ticks_to_timeout(300, idx);
    chk("R1 R7 first timeout tick", idx, 256);

    for (int v = 0; v < NV; v++) begin
      wr_mode(VEC[v][29:24]);
      wr_cnt(8'h00);
      cyc_en = 1;
      repeat (int'(VEC[v][23:8])) cyc();
      cyc_en = 0;
      chk($sformatf("R2/R3 vector %0d", v), cnt_o, VEC[v][7:0]);
    end

    // R4 rising edge, cycle enable ignored
    wr_mode(6'h28); wr_cnt(8'h00); cyc_en = 1;
    pin = 1; cyc();
    chk("R4 rise visible next cycle", cnt_o, 1);
    pin = 0; cyc();
    chk("R4 no count on fall", cnt_o, 1);
    repeat (2) begin pin = 1; cyc(); pin = 0; cyc(); end
    chk("R4 three rises", cnt_o, 3);
    // R4 falling edge
    wr_mode(6'h38); wr_cnt(8'h00);
    pin = 1; cyc();
    chk("R4 no count on rise", cnt_o, 0);
    pin = 0; cyc();
    chk("R4 fall counted", cnt_o, 1);
    // R4 with R2 prescale 1:2 on pin
    wr_mode(6'h20); wr_cnt(8'h00);
    repeat (4) begin pin = 1; cyc(); pin = 0; cyc(); end
    chk("R4 R2 pin 1:2", cnt_o, 2);
    cyc_en = 0;

    // R5 write clears prescaler (1:4)
    wr_mode(6'h01); wr_cnt(8'h00);
    cyc_en = 1; repeat (3) cyc(); cyc_en = 0;
    wr_cnt(8'h00);
    cyc_en = 1; repeat (3) cyc(); cyc_en = 0;
    chk("R5 prescaler cleared by write", cnt_o, 0);
    cyc_en = 1; cyc(); cyc_en = 0;
    chk("R5 fourth event passes", cnt_o, 1);
    // R5 write overrides increment
    wr_mode(6'h08); cyc_en = 1; wr_cnt(8'h40); cyc_en = 0;
    chk("R5 load wins", cnt_o, 8'h40);

    // R6 wrap and one-cycle pulse
    wr_cnt(8'hFE); cyc_en = 1; cyc();
    chk("R6 at FF", cnt_o, 8'hFF);
    chk("R6 no ovf at FF", ovf_o, 0);
    cyc(); cyc_en = 0;
    chk("R6 wrapped", cnt_o, 0);
    chk("R6 ovf pulse", ovf_o, 1);
    cyc();
    chk("R6 ovf one cycle", ovf_o, 0);

    // R8 watchdog 1:2
    wr_mode(6'h09); wclear();
    ticks_to_timeout(600, idx);
    chk("R8 timeout at 512", idx, 512);
    // R9 clear also clears watchdog-side prescaler
    wclear(); tick = 1; cyc(); tick = 0; wclear();
    ticks_to_timeout(600, idx);
    chk("R9 prescaler cleared by wdt clear", idx, 512);
    // R9 sleep clears count
    wr_mode(6'h00); wclear();
    ticks_to_timeout(200, idx);
    chk("R9 no timeout before sleep", idx, 0);
    slp = 1; cyc(); slp = 0;
    ticks_to_timeout(300, idx);
    chk("R9 timeout 256 after sleep", idx, 256);

    // R10 counter survives reset
    wr_mode(6'h08); wr_cnt(8'h5A);
    rst_ni = 0; cyc(); cyc();
    chk("R10 count held in reset", cnt_o, 8'h5A);
    chk("R1 mode back to default", mode_o, 6'h3F);
    rst_ni = 1; cyc();
    chk("R10 count after reset", cnt_o, 8'h5A);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule